// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block turns a fast module clock into the serial bit clock of a synchronous serial master. A 13-bit divider word chooses one of two divide laws. The linear law divides by an even count: output = module clock / (2 × (n + 1)), with an 8-bit n. The exponential law divides by a power of two: output = module clock / 2^(m + 1), with a 4-bit m. The exponential law reaches far slower rates than the linear law. It is used when the linear field cannot get down to the wanted rate.

While `run` is high, the block toggles its serial clock after every half-period. The high and low phases are always equal in length. With each toggle it raises a one-cycle strobe that tells the shift engine which edge just happened. The leading strobe marks the edge where the clock leaves its idle level. The trailing strobe marks the edge where it returns to that level. When `run` is low, the serial clock rests at the level given by `cpol` and the counter is cleared. The divider word is also taken in only while idle, so a rate change never lands in the middle of a burst.

Top module: `sdiv_top`

## Requirements
- R1: With select bit 12 at 1 (linear), each serial clock phase lasts n+1 module clocks, where n = div_cfg[7:0]. The full period is therefore 2×(n+1), with equal high and low phases. For n=255 a phase is 256 clocks.
- R2: With select bit 12 at 0 (exponential), each phase lasts 2^m module clocks, where m = div_cfg[11:8]. The period is 2^(m+1).
- R3: Bit 12 alone picks the law: 1 selects the linear field [7:0] and 0 selects the exponential field [11:8]. The field that is not selected has no effect.
- R4: A linear field of zero makes the serial clock toggle on every module clock, which is half the module clock rate.
- R5: The slowest rate, exponential with m=15, gives phases of 32768 module clocks.
- R6: The counter restarts when run goes high. If run is first sampled high at clock edge k, the first serial clock edge and its strobe appear after edge k+H−1, where H is the phase length. This is a full phase after the start.
- R7: While run is low, the serial clock takes the cpol level one clock later and no strobe is raised. If run drops mid-phase, the phase is abandoned. cpol is sampled only while idle, so a change to cpol during a burst has no effect on the clock.
- R8: A change to div_cfg while run is high has no effect until run has been low for at least one clock.
- R9: lead_stb is high for the one cycle in which sclk first shows a level other than cpol. trail_stb is high for the one cycle in which sclk returns to cpol. The two strobes are never high together.
- R10: A synchronous active-high reset sets sclk to cpol and clears both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High while a burst is in progress |
| cpol | input | 1 | Idle level of the serial clock |
| div_cfg | input | 13 | [7:0] linear field, [11:8] exponential field, [12] law select (1 = linear) |
| sclk | output | 1 | Serial clock, registered |
| lead_stb | output | 1 | One-cycle strobe on the edge leaving the idle level |
| trail_stb | output | 1 | One-cycle strobe on the edge returning to the idle level |

## Verification
The divide laws are exercised with several settings. A small linear setting tests a multi-cycle phase. A zero linear field tests the one-cycle limit. A mid-range exponential setting checks power-of-two spacing. The maximum exponential setting checks the counter width. One divider word is also run under both values of the select bit: the two phase lengths differ, which shows the field decode is correct. Further cases rewrite div_cfg and flip cpol in mid-burst, and drop run part-way through a phase. These show whether configuration is held and whether the counter restarts with a full first phase rather than finishing the abandoned one.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  // Law selected by the top bit of the divider word
  typedef enum logic {
    LAW_EXP = 1'b0,
    LAW_LIN = 1'b1
  } div_law_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdiv_cfg_hold.sv
// Samples the divider word while idle and holds it through a burst.
module sdiv_cfg_hold
  import sdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CFG_W-1:0] div_cfg,
  output logic [LIN_W-1:0] lin_n,
  output logic [EXP_W-1:0] exp_m,
  output div_law_e         law
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      lin_n <= div_cfg[LIN_W-1:0];
      exp_m <= div_cfg[LIN_W+EXP_W-1:LIN_W];
      law   <= div_law_e'(div_cfg[CFG_W-1]);
    end
  end

  // R8: held fields do not move while a burst continues
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ($stable(lin_n) && $stable(exp_m) && $stable(law)));
endmodule

// File: rtl/sdiv_limit.sv
// Turns the held fields into the terminal count (phase length minus one).
module sdiv_limit
  import sdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int LIM_W = max2(LIN_W, (1 << EXP_W) - 1)
) (
  input  logic [LIN_W-1:0] lin_n,
  input  logic [EXP_W-1:0] exp_m,
  input  div_law_e         law,
  output logic [LIM_W-1:0] lim
);
  logic [LIM_W-1:0] lin_lim;
  logic [LIM_W:0]   exp_pow;
  logic [LIM_W:0]   exp_lim_w;

  generate
    if (LIN_W < LIM_W) begin : g_lin_ext
      assign lin_lim = {{(LIM_W-LIN_W){1'b0}}, lin_n};
    end else begin : g_lin_same
      assign lin_lim = lin_n;
    end
  endgenerate

  always_comb begin
    exp_pow   = (LIM_W+1)'(1) << exp_m;
    exp_lim_w = exp_pow - (LIM_W+1)'(1);
    lim       = (law == LAW_LIN) ? lin_lim : exp_lim_w[LIM_W-1:0];
  end
endmodule

// File: rtl/sdiv_tick.sv
// Phase counter: pulses tick on the last module clock of each phase.
module sdiv_tick #(
  parameter int LIM_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [LIM_W-1:0] lim,
  output logic             tick
);
  logic [LIM_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == lim)  cnt <= '0;
    else                  cnt <= cnt + LIM_W'(1);
  end

  assign tick = run && (cnt == lim);

  // R1/R2: the count never passes the terminal value during a burst
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= lim));
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
  import sdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1,
  localparam int LIM_W = max2(LIN_W, (1 << EXP_W) - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cpol,
  input  logic [CFG_W-1:0] div_cfg,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_m;
  div_law_e         law;
  logic [LIM_W-1:0] lim;
  logic             tick;
  logic             away;

  sdiv_cfg_hold #(.LIN_W(LIN_W), .EXP_W(EXP_W)) cfg_i (
    .clk(clk), .rst(rst), .run(run), .div_cfg(div_cfg),
    .lin_n(lin_n), .exp_m(exp_m), .law(law)
  );

  sdiv_limit #(.LIN_W(LIN_W), .EXP_W(EXP_W)) lim_i (
    .lin_n(lin_n), .exp_m(exp_m), .law(law), .lim(lim)
  );

  sdiv_tick #(.LIM_W(LIM_W)) tick_i (
    .clk(clk), .rst(rst), .run(run), .lim(lim), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk      <= cpol;
      away      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= tick && !away;
      trail_stb <= tick && away;
      if (tick) begin
        sclk <= ~sclk;
        away <= ~away;
      end
    end
  end

  // R7: idle forces the cpol level and silences the strobes
  assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == $past(cpol) && !lead_stb && !trail_stb));

  // R9: strobes are exclusive
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(lead_stb && trail_stb));

  // R9: every strobe coincides with an sclk change made while running
  assert_strobe_moves_R9: assert property (@(posedge clk) disable iff (rst)
    (lead_stb || trail_stb) |-> ($past(run) && sclk != $past(sclk)));

  // R9: every sclk change during a burst carries a strobe
  assert_edge_strobed_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && run && sclk != $past(sclk)) |-> (lead_stb || trail_stb));
endmodule

// File: tb/sdiv_top_tb.sv
module sdiv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic [12:0] div_cfg = '0;
  logic        sclk, lead_stb, trail_stb;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  string cur_req = "R10";

  // Reference model state
  int m_cnt = 0;
  int m_half = 1;
  bit m_away = 0;
  logic m_sclk = 1'b0, m_lead = 1'b0, m_trail = 1'b0;

  always #2 clk = ~clk;

  sdiv_top dut_i (
    .clk(clk), .rst(rst), .run(run), .cpol(cpol), .div_cfg(div_cfg),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  function automatic int half_of(input logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    return 1 << c[11:8];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst || !run) begin
      m_sclk = cpol; m_lead = 0; m_trail = 0;
      m_cnt = 0; m_away = 0; m_half = half_of(div_cfg);
    end else begin
      m_lead = 0; m_trail = 0;
      m_cnt++;
      if (m_cnt == m_half) begin
        m_cnt = 0;
        m_sclk = ~m_sclk;
        if (!m_away) m_lead = 1; else m_trail = 1;
        m_away = ~m_away;
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (sclk !== m_sclk || lead_stb !== m_lead || trail_stb !== m_trail) begin
      miscompares++;
      $display("FAIL %s cycle %0d: sclk/lead/trail act %b%b%b exp %b%b%b",
               cur_req, cyc, sclk, lead_stb, trail_stb, m_sclk, m_lead, m_trail);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  // Counts negedges until the chosen strobe is seen
  task automatic wait_stb(input bit want_lead, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_lead ? lead_stb : trail_stb) && n < 70000);
  endtask

  task automatic start(input logic [12:0] c, input logic pol);
    @(negedge clk);
    div_cfg = c; cpol = pol; run = 1'b0;
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    // R10: reset state with both polarities
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", int'(sclk), 1);
    check("R10", int'(lead_stb | trail_stb), 0);
    cpol = 1'b0;
    @(negedge clk);
    check("R10", int'(sclk), 0);
    rst = 1'b0;

    // R1, R6: linear n=3, phase 4
    cur_req = "R1";
    start(13'h1003, 1'b0);
    wait_stb(1, n); check("R6", n, 4);
    wait_stb(0, n); check("R1", n, 4);
    wait_stb(1, n); check("R1", n, 4);
    stop();

    // R1: linear n=255, phase 256
    start(13'h10FF, 1'b0);
    wait_stb(1, n); check("R1", n, 256);
    wait_stb(0, n); check("R1", n, 256);
    stop();

    // R4: linear zero toggles every clock
    cur_req = "R4";
    start(13'h1000, 1'b1);
    wait_stb(1, n); check("R4", n, 1);
    wait_stb(0, n); check("R4", n, 1);
    wait_stb(1, n); check("R4", n, 1);
    stop();

    // R2: exponential m=2, phase 4, cpol high
    cur_req = "R2";
    start(13'h0200, 1'b1);
    wait_stb(1, n); check("R2", n, 4);
    check("R9", int'(sclk), 0);
    wait_stb(0, n); check("R2", n, 4);
    check("R9", int'(sclk), 1);
    stop();

    // R3: same fields, both select values
    cur_req = "R3";
    start(13'h1105, 1'b0);
    wait_stb(1, n); check("R3", n, 6);
    stop();
    start(13'h0105, 1'b0);
    wait_stb(1, n); check("R3", n, 2);
    stop();

    // R8: rewrite config mid-burst, takes effect after idle
    cur_req = "R8";
    start(13'h1002, 1'b0);
    wait_stb(1, n); check("R8", n, 3);
    div_cfg = 13'h1007;
    wait_stb(0, n); check("R8", n, 3);
    wait_stb(1, n); check("R8", n, 3);
    stop();
    @(negedge clk);
    run = 1'b1;
    wait_stb(1, n); check("R8", n, 8);

    // R7: cpol flip mid-burst ignored
    cur_req = "R7";
    cpol = 1'b1;
    wait_stb(0, n); check("R7", n, 8);
    check("R7", int'(sclk), 0);
    stop();
    check("R7", int'(sclk), 1);

    // R7, R6: abandon mid-phase, restart with full phase
    start(13'h1009, 1'b1);
    wait_stb(1, n); check("R6", n, 10);
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check("R7", int'(sclk), 1);
    check("R7", int'(lead_stb | trail_stb), 0);
    run = 1'b1;
    wait_stb(1, n); check("R6", n, 10);
    stop();

    // R5: slowest setting
    cur_req = "R5";
    start(13'h0F00, 1'b0);
    wait_stb(1, n); check("R5", n, 32768);
    stop();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule